// File: doc/BRIEF.md
# Framed Serial Control-Port Master

This block drives the four-wire control port of a serial peripheral (chip select, serial clock, output data, input data) and carries out one complete register transaction for each start request. The host presents a device address byte, a register map byte, a write byte and a read/write select, pulses start, and later receives a one-cycle done pulse. For reads, the returned byte is presented on the read-data output with that pulse.

A write is one chip-select frame holding the device address with its least significant bit cleared, then the map byte, then the data byte. A read takes two frames. The first frame sets the peripheral's map pointer by sending the address with bit 0 cleared and then the map byte. Chip select is raised between the frames. The second frame sends the address with bit 0 set and then clocks in one byte. The address least significant bit is always forced by the block and acts as the read/write flag. A typical use is the input-source select of an audio receiver: device 0x20, map 0x04, data 0x80 | (source << 3) for a source index from 0 to 2.

Each bit takes three phases of `HALF_DIV` system clocks each. In the first phase the clock is low. In the second phase the clock stays low and the data bit is presented. In the third phase the clock is high. Bytes go out and come in most significant bit first.

Top module: `serial_ctl_master`

## Requirements
- R1: After reset, and whenever no transaction is running, cs_n is 1, sclk is 1, mosi is 0 and done is 0.
- R2: A write (rd_req = 0) produces exactly one frame of three bytes, in this order: {dev_addr[7:1], 0}, reg_map, wr_data. Each byte is sent most significant bit first, and mosi is valid at each sclk rising edge.
- R3: A read (rd_req = 1) produces two frames. The first frame holds {dev_addr[7:1], 0} followed by reg_map. The second frame holds {dev_addr[7:1], 1} followed by eight read clocks, during which mosi is 0. rd_data then equals the eight miso bits taken most significant bit first.
- R4: Within a frame, sclk stays low for 2*HALF_DIV cycles per bit and high for HALF_DIV cycles. mosi changes only while sclk is low, exactly HALF_DIV cycles after sclk falls.
- R5: miso is sampled in the last cycle of the clock-low time of each read bit, before sclk rises.
- R6: cs_n falls HALF_DIV cycles before the first sclk fall of a frame and rises HALF_DIV cycles after the last sclk rise. Between the two frames of a read, cs_n stays high for exactly HALF_DIV cycles.
- R7: done is a single-cycle pulse that comes HALF_DIV cycles after the final rise of cs_n, exactly once per accepted start. rd_data is valid while done is high.
- R8: A start pulse that arrives while a transaction is running has no effect. No extra frame or done pulse follows, and the bytes on the line are those of the first request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, sampled only while idle |
| rd_req | input | 1 | 1 = read transaction, 0 = write |
| dev_addr | input | 8 | Device address byte; bit 0 is replaced by the direction flag |
| reg_map | input | 8 | Register map byte |
| wr_data | input | 8 | Data byte for writes |
| rd_data | output | 8 | Byte returned by a read, valid with done |
| done | output | 1 | One-cycle completion pulse |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, idles high |
| mosi | output | 1 | Serial data to the peripheral |
| miso | input | 1 | Serial data from the peripheral |

## Verification
Every serial event is a fixed number of cycles after the previous one, so the bench timestamps each edge of cs_n, sclk and mosi against a free-running cycle count. It checks each gap against the requirement: 2*HALF_DIV for the clock-low time, HALF_DIV for the data change, for the chip-select lead and trail, and for the gap between read frames, and HALF_DIV again from the last chip-select rise to done. All line observations are taken on the falling system-clock edge, half a cycle after the registered outputs move. The bench's peripheral model drives miso at the same falling edge that sees sclk drop, which leaves 2*HALF_DIV - 1 cycles before the design's sampling point.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;

    localparam int BYTE_W = 8;
    localparam int BIT_IDX_W = $clog2(BYTE_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CS_LEAD,
        ST_BIT_LOW,
        ST_BIT_DRIVE,
        ST_BIT_HIGH,
        ST_CS_TRAIL,
        ST_DONE
    } seq_state_e;

    // Byte positions inside a transaction; a read skips SLOT_DATA.
    typedef enum logic [2:0] {
        SLOT_DEV_W,
        SLOT_MAP,
        SLOT_DATA,
        SLOT_DEV_R,
        SLOT_READ
    } slot_e;

    typedef struct packed {
        logic              rd;
        logic [BYTE_W-1:0] dev;
        logic [BYTE_W-1:0] map;
        logic [BYTE_W-1:0] wdata;
    } req_t;

    function automatic slot_e slot_after(slot_e s, logic rd);
        case (s)
            SLOT_DEV_W: return SLOT_MAP;
            SLOT_MAP:   return rd ? SLOT_DEV_R : SLOT_DATA;
            SLOT_DEV_R: return SLOT_READ;
            default:    return s;
        endcase
    endfunction

    function automatic logic closes_frame(slot_e s, logic rd);
        return (s == SLOT_MAP && rd) || (s == SLOT_DATA) || (s == SLOT_READ);
    endfunction

    function automatic logic [BYTE_W-1:0] slot_byte(slot_e s, req_t r);
        case (s)
            SLOT_DEV_W: return {r.dev[BYTE_W-1:1], 1'b0};
            SLOT_MAP:   return r.map;
            SLOT_DATA:  return r.wdata;
            SLOT_DEV_R: return {r.dev[BYTE_W-1:1], 1'b1};
            default:    return '0;
        endcase
    endfunction

endpackage

// File: rtl/phase_timer.sv
module phase_timer #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) cnt <= '0;
        else                     cnt <= cnt + 1'b1;
    end

    assert_phase_bound_R4: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);
    assert_idle_count_R4: assert property (@(posedge clk) disable iff (rst)
        !run |=> cnt == '0);
endmodule

// File: rtl/byte_shifter.sv
module byte_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         sin,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)        q <= '0;
        else if (load)  q <= load_val;
        else if (shift) q <= {q[W-2:0], sin};
    end

    assert_exclusive_ops_R2: assert property (@(posedge clk) disable iff (rst)
        !(load && shift));
    assert_shift_moves_R5: assert property (@(posedge clk) disable iff (rst)
        shift |=> q[W-1:1] == $past(q[W-2:0]));
endmodule

// File: rtl/ctl_sequencer.sv
module ctl_sequencer
    import spi_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  req_t              req_in,
    input  logic              tick,
    input  logic [BYTE_W-1:0] sh_q,
    output logic              run,
    output logic              sh_load,
    output logic [BYTE_W-1:0] sh_load_val,
    output logic              sh_shift,
    output logic              cs_n,
    output logic              sclk,
    output logic              mosi,
    output logic              done,
    output logic [BYTE_W-1:0] rd_data
);
    seq_state_e           state;
    slot_e                slot;
    req_t                 req_q;
    logic [BIT_IDX_W-1:0] bit_idx;
    logic                 last_bit;
    logic                 frame_end;

    assign last_bit  = (bit_idx == BIT_IDX_W'(BYTE_W - 1));
    assign frame_end = closes_frame(slot, req_q.rd);
    assign run       = (state != ST_IDLE) && (state != ST_DONE);

    always_comb begin
        sh_load     = 1'b0;
        sh_load_val = slot_byte(slot, req_q);
        if (tick && state == ST_CS_LEAD) begin
            sh_load = 1'b1;
        end else if (tick && state == ST_BIT_HIGH && last_bit && !frame_end) begin
            sh_load     = 1'b1;
            sh_load_val = slot_byte(slot_after(slot, req_q.rd), req_q);
        end
    end

    assign sh_shift = tick && (state == ST_BIT_DRIVE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            slot    <= SLOT_DEV_W;
            req_q   <= '0;
            bit_idx <= '0;
            cs_n    <= 1'b1;
            sclk    <= 1'b1;
            mosi    <= 1'b0;
            done    <= 1'b0;
            rd_data <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        req_q <= req_in;
                        slot  <= SLOT_DEV_W;
                        cs_n  <= 1'b0;
                        state <= ST_CS_LEAD;
                    end
                end
                ST_CS_LEAD: begin
                    if (tick) begin
                        bit_idx <= '0;
                        sclk    <= 1'b0;
                        state   <= ST_BIT_LOW;
                    end
                end
                ST_BIT_LOW: begin
                    if (tick) begin
                        mosi  <= (slot == SLOT_READ) ? 1'b0 : sh_q[BYTE_W-1];
                        state <= ST_BIT_DRIVE;
                    end
                end
                ST_BIT_DRIVE: begin
                    if (tick) begin
                        sclk  <= 1'b1;
                        state <= ST_BIT_HIGH;
                    end
                end
                ST_BIT_HIGH: begin
                    if (tick) begin
                        if (!last_bit) begin
                            bit_idx <= bit_idx + 1'b1;
                            sclk    <= 1'b0;
                            state   <= ST_BIT_LOW;
                        end else if (frame_end) begin
                            cs_n  <= 1'b1;
                            state <= ST_CS_TRAIL;
                        end else begin
                            slot    <= slot_after(slot, req_q.rd);
                            bit_idx <= '0;
                            sclk    <= 1'b0;
                            state   <= ST_BIT_LOW;
                        end
                    end
                end
                ST_CS_TRAIL: begin
                    if (tick) begin
                        if (slot == SLOT_MAP) begin
                            slot  <= SLOT_DEV_R;
                            cs_n  <= 1'b0;
                            state <= ST_CS_LEAD;
                        end else begin
                            if (req_q.rd) rd_data <= sh_q;
                            done  <= 1'b1;
                            state <= ST_DONE;
                        end
                    end
                end
                default: begin
                    mosi  <= 1'b0;
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    assert_idle_lines_R1: assert property (@(posedge clk) disable iff (rst)
        state == ST_IDLE |-> (cs_n && sclk && !mosi && !done));
    assert_mosi_held_high_R4: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && sclk && $past(sclk) && $past(!cs_n)) |-> $stable(mosi));
    assert_read_mosi_low_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_BIT_HIGH && slot == SLOT_READ) |-> !mosi);
    assert_clock_inside_frame_R6: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> sclk);
    assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE && start) |=> $stable(req_q));
endmodule

// File: rtl/serial_ctl_master.sv
module serial_ctl_master
    import spi_ctl_pkg::*;
#(
    parameter int HALF_DIV = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              rd_req,
    input  logic [BYTE_W-1:0] dev_addr,
    input  logic [BYTE_W-1:0] reg_map,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_data,
    output logic              done,
    output logic              cs_n,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso
);
    req_t              req_in;
    logic              run;
    logic              tick;
    logic              sh_load;
    logic              sh_shift;
    logic [BYTE_W-1:0] sh_load_val;
    logic [BYTE_W-1:0] sh_q;

    assign req_in = '{rd: rd_req, dev: dev_addr, map: reg_map, wdata: wr_data};

    phase_timer #(.HALF_DIV(HALF_DIV)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .tick (tick)
    );

    byte_shifter #(.W(BYTE_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .load     (sh_load),
        .load_val (sh_load_val),
        .shift    (sh_shift),
        .sin      (miso),
        .q        (sh_q)
    );

    ctl_sequencer u_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .req_in      (req_in),
        .tick        (tick),
        .sh_q        (sh_q),
        .run         (run),
        .sh_load     (sh_load),
        .sh_load_val (sh_load_val),
        .sh_shift    (sh_shift),
        .cs_n        (cs_n),
        .sclk        (sclk),
        .mosi        (mosi),
        .done        (done),
        .rd_data     (rd_data)
    );
endmodule

// File: tb/serial_ctl_master_test.sv
module serial_ctl_master_test;
    localparam int DIV = 4;
    localparam int NV  = 8;
    // {rd, dev, map, wdata, slave byte}
    localparam logic [32:0] VEC [NV] = '{
        {1'b0, 8'h20, 8'h04, 8'h80, 8'h00},
        {1'b0, 8'h20, 8'h04, 8'h88, 8'h00},
        {1'b0, 8'h20, 8'h04, 8'h90, 8'h00},
        {1'b0, 8'h21, 8'h05, 8'h05, 8'h00},
        {1'b1, 8'h20, 8'h7f, 8'h00, 8'hA5},
        {1'b1, 8'h21, 8'h26, 8'hFF, 8'h3C},
        {1'b0, 8'h34, 8'h00, 8'hFF, 8'h00},
        {1'b1, 8'h20, 8'h00, 8'h00, 8'h81}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic rd_req = 1'b0;
    logic [7:0] dev_addr = '0, reg_map = '0, wr_data = '0;
    logic [7:0] rd_data;
    logic done, cs_n, sclk, mosi;
    logic miso = 1'b0;

    always #2 clk = ~clk;

    serial_ctl_master #(.HALF_DIV(DIV)) uut (
        .clk(clk), .rst(rst), .start(start), .rd_req(rd_req),
        .dev_addr(dev_addr), .reg_map(reg_map), .wr_data(wr_data),
        .rd_data(rd_data), .done(done), .cs_n(cs_n), .sclk(sclk),
        .mosi(mosi), .miso(miso)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Line monitor and peripheral model, all on the falling clock edge.
    logic [7:0] slave_byte = '0;
    int cyc = 0;
    int frames_total = 0;
    int done_cnt = 0;
    int done_gap = 0;
    int last_done_cyc = 0;
    int tmg_bad = 0;
    logic [7:0] rd_at_done = '0;
    logic [7:0] fb [16][4];
    int flen [16];
    int bits = 0;
    int fi = 0;
    int t_csfall = 0, t_csrise = 0, t_sfall = 0, t_srise = 0;
    logic [7:0] cur = '0;
    logic p_cs = 1'b1, p_sclk = 1'b1, p_mosi = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (p_cs && !cs_n) begin
                if (frames_total > 0 && t_csrise > last_done_cyc && cyc - t_csrise != DIV) begin
                    tmg_bad++; $display("note R6 frame gap %0d", cyc - t_csrise);
                end
                bits = 0; t_csfall = cyc; fi = frames_total % 16; flen[fi] = 0;
            end
            if (!cs_n && p_sclk && !sclk) begin
                if (bits == 0 && cyc - t_csfall != DIV) begin
                    tmg_bad++; $display("note R6 lead %0d", cyc - t_csfall);
                end
                if (bits != 0 && cyc - t_srise != DIV) begin
                    tmg_bad++; $display("note R4 high %0d", cyc - t_srise);
                end
                t_sfall = cyc;
                if (bits >= 8 && fb[fi][0][0]) miso <= slave_byte[7 - (bits - 8)];
                else                           miso <= 1'b0;
            end
            if (!cs_n && !p_sclk && sclk) begin
                if (cyc - t_sfall != 2*DIV) begin
                    tmg_bad++; $display("note R4 low %0d", cyc - t_sfall);
                end
                t_srise = cyc;
                cur = {cur[6:0], mosi};
                bits++;
                if (bits % 8 == 0 && flen[fi] < 4) begin
                    fb[fi][flen[fi]] = cur;
                    flen[fi]++;
                end
            end
            if (!cs_n && mosi != p_mosi && (sclk || cyc - t_sfall != DIV)) begin
                tmg_bad++; $display("note R4 mosi change at %0d", cyc - t_sfall);
            end
            if (!p_cs && cs_n) begin
                if (cyc - t_srise != DIV) begin
                    tmg_bad++; $display("note R6 trail %0d", cyc - t_srise);
                end
                t_csrise = cyc;
                frames_total++;
            end
            if (done) begin
                done_cnt++; done_gap = cyc - t_csrise; last_done_cyc = cyc;
                rd_at_done = rd_data;
            end
        end
        p_cs = cs_n; p_sclk = sclk; p_mosi = mosi;
    end

    // Watchdog: a hung run is a failed check and still reaches the summary.
    always @(negedge clk) begin
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic pulse_start(input logic r, input logic [7:0] d, input logic [7:0] m,
                               input logic [7:0] w);
        @(negedge clk);
        rd_req = r; dev_addr = d; reg_map = m; wr_data = w; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input int d0);
        for (int k = 0; k < 4000 && done_cnt == d0; k++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic check_idle(input string tag);
        chk(cs_n == 1'b1, "R1", {tag, " cs_n idle"}, cs_n, 1);
        chk(sclk == 1'b1, "R1", {tag, " sclk idle"}, sclk, 1);
        chk(mosi == 1'b0, "R1", {tag, " mosi idle"}, mosi, 0);
        chk(done == 1'b0, "R1", {tag, " done idle"}, done, 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_idle("reset");

        for (int v = 0; v < NV; v++) begin
            logic r; logic [7:0] d, m, w, s;
            int f0, d0, b0, i0, i1;
            {r, d, m, w, s} = VEC[v];
            slave_byte = s;
            f0 = frames_total; d0 = done_cnt; b0 = tmg_bad;
            i0 = f0 % 16; i1 = (f0 + 1) % 16;
            pulse_start(r, d, m, w);
            wait_done(d0);
            chk(done_cnt - d0 == 1, "R7", "done pulses", done_cnt - d0, 1);
            chk(done_gap == DIV, "R7", "cs rise to done", done_gap, DIV);
            chk(tmg_bad == b0, "R4", "phase timing (R5 R6)", tmg_bad - b0, 0);
            if (!r) begin
                chk(frames_total - f0 == 1, "R2", "frame count", frames_total - f0, 1);
                chk(flen[i0] == 3, "R2", "byte count", flen[i0], 3);
                chk(fb[i0][0] == {d[7:1], 1'b0}, "R2", "address byte", fb[i0][0], {d[7:1], 1'b0});
                chk(fb[i0][1] == m, "R2", "map byte", fb[i0][1], m);
                chk(fb[i0][2] == w, "R2", "data byte", fb[i0][2], w);
            end else begin
                chk(frames_total - f0 == 2, "R3", "frame count", frames_total - f0, 2);
                chk(flen[i0] == 2, "R3", "pointer frame bytes", flen[i0], 2);
                chk(fb[i0][0] == {d[7:1], 1'b0}, "R3", "pointer address", fb[i0][0], {d[7:1], 1'b0});
                chk(fb[i0][1] == m, "R3", "pointer map", fb[i0][1], m);
                chk(flen[i1] == 2, "R3", "read frame bytes", flen[i1], 2);
                chk(fb[i1][0] == {d[7:1], 1'b1}, "R3", "read address", fb[i1][0], {d[7:1], 1'b1});
                chk(fb[i1][1] == 8'h00, "R3", "mosi during read", fb[i1][1], 0);
                chk(rd_at_done == s, "R5", "read byte at done", rd_at_done, s);
            end
            check_idle("after txn");
        end

        // R8: a second start in mid-transaction must be dropped.
        begin
            int f0, d0, i0;
            f0 = frames_total; d0 = done_cnt; i0 = f0 % 16;
            pulse_start(1'b0, 8'h20, 8'h04, 8'h98);
            repeat (40) @(negedge clk);
            pulse_start(1'b1, 8'h34, 8'h11, 8'h00);
            wait_done(d0);
            repeat (600) @(negedge clk);
            chk(done_cnt - d0 == 1, "R8", "done count", done_cnt - d0, 1);
            chk(frames_total - f0 == 1, "R8", "frame count", frames_total - f0, 1);
            chk(fb[i0][0] == 8'h20, "R8", "address kept", fb[i0][0], 8'h20);
            chk(fb[i0][2] == 8'h98, "R8", "data kept", fb[i0][2], 8'h98);
            check_idle("after ignored start");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule